// File: doc/BRIEF.md
# Pacer Capture and Pulse Timer

This block runs a free-running timer that marks when a pacemaker spike is seen on an ECG front end and shapes two timing pulses for the acquisition path. A pacer detector drives an active-low input. Each falling edge on that input latches the current timer count into a capture register and sets an interrupt flag. The flag stays set until software clears it.

Two pulse channels share the timer. The blanking channel is armed by a mode bit that selects external-pacer operation. In that mode a pacer edge sets the blanking output at once, in hardware, so the front end can be blanked without waiting for interrupt service. The output falls when the timer has advanced by the programmed blanking length. When the mode bit is clear, the blanking output stays low. The trigger channel is started by a software command and produces a high pulse whose length, in timer ticks, is programmed separately.

Software reaches the block through a small register file with single-cycle write and read strobes. The timer advances once every (divider+1) clock cycles.

Top module: `pacer_timer`

## Requirements
- R1: Each falling edge of `pace_n`, as seen at a rising clock edge, sets `irq` from the next cycle on. `irq` is also readable as STATUS (address 4) bit 0.
- R2: On that same edge, the timer count present in that cycle is stored in CAPTURE (address 5, read-only).
- R3: Writing STATUS with bit 0 set clears the flag. Writing STATUS with bit 0 clear leaves the flag unchanged. A new pacer edge in the same cycle as a clear keeps the flag set.
- R4: The timer COUNT (address 6, read-only) advances by one every (DIV+1) clocks. DIV is CTRL (address 0) bits [15:8]. DIV=0 advances the count every clock.
- R5: When CTRL bit 0 (external-pacer mode) is 0, `blank` is low in every cycle after the first clock edge at which the mode bit reads 0.
- R6: In external-pacer mode with BLANK_LEN (address 1) equal to N>0, and DIV=0, `blank` rises in the cycle after the pacer edge and stays high for exactly N cycles.
- R7: A pacer edge that arrives while `blank` is high restarts the blanking length from that edge.
- R8: Writing CMD (address 3) with bit 0 set starts the trigger. With TRIG_LEN (address 2) equal to N>0 and DIV=0, `trig` rises in the next cycle and stays high for exactly N cycles.
- R9: A blanking or trigger length of zero produces no pulse.
- R10: `rdata` shows the addressed register while `rd_en` is high and reads zero otherwise. STATUS bit 1 reflects `blank` and bit 2 reflects `trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pace_n | input | 1 | Pacer detect, falling edge marks a detection |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data (combinational) |
| irq | output | 1 | Capture interrupt flag |
| blank | output | 1 | Blanking pulse |
| trig | output | 1 | Trigger pulse |

## Verification
The blanking channel is driven from a table of mode and length pairs. The lengths 1, 4 and 9 show that the pulse width follows the programmed value exactly and is not off by one. A pair with the mode bit cleared, and a pair with zero length, separate a suppressed pulse from a short one. Directed cases add the following:
- a second pacer edge in the middle of a pulse, which tells a restart apart from a pulse that simply runs out;
- a capture compared against the count read in the cycle of the edge;
- two counts taken under a divider of 3;
- status writes with bit 0 clear and with bit 0 set, which show that only a one clears the flag.

// File: rtl/pacer_timer.sv
module pacer_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pace_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic             blank,
  output logic             trig
);
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_BLEN  = 3'd1;
  localparam logic [2:0] A_TLEN  = 3'd2;
  localparam logic [2:0] A_CMD   = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_CAP   = 3'd5;
  localparam logic [2:0] A_CNT   = 3'd6;
  localparam int         DIV_LSB = CNT_W - PRE_W;

  logic             ext_mode;
  logic [PRE_W-1:0] div, pre_cnt;
  logic [CNT_W-1:0] count, cap, blank_len, trig_len, blank_cmp, trig_cmp;
  logic             pace_q;

  wire tick  = (pre_cnt == div);
  wire fall  = pace_q & ~pace_n;
  wire start = wr_en && (addr == A_CMD) && wdata[0];
  wire clr   = wr_en && (addr == A_STAT) && wdata[0];
  wire arm_b = ext_mode && fall && (blank_len != '0);
  wire arm_t = start && (trig_len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_mode  <= 1'b0;
      div       <= '0;
      blank_len <= '0;
      trig_len  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          ext_mode <= wdata[0];
          div      <= wdata[CNT_W-1:DIV_LSB];
        end
        A_BLEN:  blank_len <= wdata;
        A_TLEN:  trig_len  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      count   <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      count   <= count + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pace_q <= 1'b1;
      cap    <= '0;
      irq    <= 1'b0;
    end else begin
      pace_q <= pace_n;
      if (fall) begin
        cap <= count;
        irq <= 1'b1;
      end else if (clr) begin
        irq <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank     <= 1'b0;
      blank_cmp <= '0;
    end else if (!ext_mode) begin
      blank <= 1'b0;
    end else if (arm_b) begin
      blank     <= 1'b1;
      blank_cmp <= count + blank_len;
    end else if (blank && count == blank_cmp) begin
      blank <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig     <= 1'b0;
      trig_cmp <= '0;
    end else if (arm_t) begin
      trig     <= 1'b1;
      trig_cmp <= count + trig_len;
    end else if (trig && count == trig_cmp) begin
      trig <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = {div, {(DIV_LSB-1){1'b0}}, ext_mode};
        A_BLEN:  rdata = blank_len;
        A_TLEN:  rdata = trig_len;
        A_STAT:  rdata = {{(CNT_W-3){1'b0}}, trig, blank, irq};
        A_CAP:   rdata = cap;
        A_CNT:   rdata = count;
        default: rdata = '0;
      endcase
    end
  end

  a_r1_edge_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> irq);
  a_r2_capture_count: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (cap == $past(count)));
  a_r3_clear_only_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fall && !clr) |=> irq);
  a_r5_conv_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |=> !blank);
  a_r6_blank_rises: assert property (@(posedge clk) disable iff (!rst_n)
    arm_b |=> blank);
  a_r8_trig_rises: assert property (@(posedge clk) disable iff (!rst_n)
    arm_t |=> trig);
  a_r9_zero_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (start && trig_len == '0 && !trig) |=> !trig);
endmodule

// File: tb/tb_pacer_timer.sv
module tb_pacer_timer;
  localparam int PERIOD = 10;
  localparam int NV     = 5;
  // {mode, length[15:0], expected high cycles[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'd4, 8'd4}, {1'b1, 16'd1, 8'd1}, {1'b1, 16'd9, 8'd9},
    {1'b0, 16'd6, 8'd0}, {1'b1, 16'd0, 8'd0}};

  logic clk = 0, rst_n = 0, pace_n = 1, wr_en = 0, rd_en = 0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, blank, trig;
  int total = 0, bad = 0;

  pacer_timer dut (.clk(clk), .rst_n(rst_n), .pace_n(pace_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .blank(blank), .trig(trig));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    rd_en = 0;
  endtask

  task automatic count_high(input bit which, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (which ? trig : blank) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d, c0, c1;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset irq", irq, 0);
    chk("R5 reset blank", blank, 0);
    chk("R8 reset trig", trig, 0);
    rd(3'd0, d); chk("R10 reset ctrl", d, 0);
    chk("R10 idle rdata", rdata, 0);

    for (int v = 0; v < NV; v++) begin
      wr(3'd0, {8'd0, 7'd0, VEC[v][24]});
      wr(3'd1, VEC[v][23:8]);
      @(negedge clk); pace_n = 0;
      @(negedge clk); pace_n = 1;
      count_high(0, n);
      chk(VEC[v][24] ? ((VEC[v][23:8] == 0) ? "R9 zero blank" : "R6 blank width")
                     : "R5 conv mode low", n, int'(VEC[v][7:0]));
      chk("R1 irq per edge", irq, 1);
      wr(3'd4, 16'd1);
    end

    // R2 capture
    wr(3'd0, 16'd1); wr(3'd1, 16'd3);
    @(negedge clk); pace_n = 0; rd_en = 1; addr = 3'd6; #1 c0 = rdata; rd_en = 0;
    @(negedge clk); pace_n = 1;
    chk("R1 irq set", irq, 1);
    rd(3'd4, d); chk("R10 status irq bit", d[0], 1);
    rd(3'd5, d); chk("R2 capture value", d, c0);

    // R3 W1C
    wr(3'd4, 16'd0); chk("R3 zero write keeps flag", irq, 1);
    wr(3'd4, 16'd1); chk("R3 one write clears", irq, 0);
    repeat (5) @(negedge clk);

    // R7 restart
    wr(3'd1, 16'd5);
    @(negedge clk); pace_n = 0;
    @(negedge clk); pace_n = 1;
    n = 0;
    if (blank) n++;
    @(negedge clk); if (blank) n++;
    @(negedge clk); if (blank) n++; pace_n = 0;
    rd(3'd4, d); chk("R10 status blank bit", d[1], 1);
    n++;
    pace_n = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (blank) n++;
    end
    chk("R7 restart length", n, 8);
    wr(3'd4, 16'd1);

    // R8 trigger
    wr(3'd2, 16'd6);
    wr(3'd3, 16'd1);
    chk("R8 trig rises", trig, 1);
    count_high(1, n); chk("R8 trig width", n, 6);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd1);
    count_high(1, n); chk("R9 zero trig", n, 0);

    // R4 prescaler
    wr(3'd0, {8'd3, 8'd1});
    rd(3'd6, c0);
    repeat (7) @(negedge clk);
    rd(3'd6, c1);
    chk("R4 prescale step", int'(c1 - c0), 2);
    rd(3'd0, d); chk("R10 ctrl readback", d, 16'h0301);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule